// File: doc/BRIEF.md
# Frame-Match Interrupt Controller

This block gathers eight interrupt sources behind one 32-bit control and status word and drives a single interrupt line. One source is internal: a frame counter advances on each frame strobe from the serial engine. When the counter takes on a value equal to a software-loaded target, the frame source fires. The other seven sources are single-cycle event pulses supplied by neighbouring logic: message, new peak, clocks stopped, external sync error, external sync good, new sample rate and status.

Each source owns two adjacent bits in the upper half of the control word. The enable bit is the higher of the two and the pending bit sits directly below it. A pending bit records its event whether or not the source is enabled. The interrupt line reflects only the sources that are both enabled and pending. Software reaches the control word, the frame counter and the target value through a flat register port. Reads are combinational and writes take effect on the clock edge.

Top module: `fmirq_ctrl`

## Requirements
- R1: After reset the control word, frame counter and target all read 0 and `irq_o` is low.
- R2: Source k (k = 0 for the frame match, k = 1..7 for `evt_i[k-1]`, with `evt_i[0]` message and `evt_i[6]` status) has its enable at control bit 31-2k and its pending flag at bit 30-2k. The frame match therefore uses bits 31/30 and status uses bits 17/16.
- R3: An event sets its pending flag on the next clock edge even when its enable is 0. A disabled source never raises `irq_o`.
- R4: A control write loads all eight enables from the written data. A 1 written to a pending position clears that flag, and a 0 leaves it unchanged. An event in the same cycle as the clear wins, so the flag stays set.
- R5: `irq_o` is high exactly when some source is both enabled and pending. It is visible in the same cycle as the control word that causes it.
- R6: The frame counter (CNT_W bits) increments once per cycle with `frame_stb_i` high and wraps from all-ones to 0.
- R7: Any write to the counter offset clears it to 0, whatever the data. The clear takes precedence over a simultaneous strobe.
- R8: The frame source's pending flag is set on the edge at which the counter changes to a value equal to the target. It is not set again while the counter holds that value, and a target write equal to the current count does not set it.
- R9: Control bits 15..0 always read 0 and ignore writes.
- R10: Offsets 0x00 (control), 0x40 (counter) and 0x50 (target) are decoded exactly. Every other offset reads 0 and its writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb_i | input | 1 | One frame has passed (one cycle per frame) |
| evt_i | input | 7 | Event pulses for sources 1..7 |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wen_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong pending or enable flag shows up in the control word and on `irq_o` in the cycle after the edge that stored it. Nothing else buffers these flags, so a stuck or swapped bit is visible at once. A counter fault is harder to spot. An off-by-one increment or a missed wrap only becomes visible when the frame flag fires at the wrong strobe or fires twice. For that reason the bench sweeps every target value over a full counter period and records the exact strobe at which the flag rises.

// File: rtl/fmirq_pkg.sv
package fmirq_pkg;

   localparam int unsigned SRC_N   = 8;
   localparam int unsigned REG_W   = 32;
   localparam int unsigned FIELD_W = 2 * SRC_N;
   localparam int unsigned ZERO_W  = REG_W - FIELD_W;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_COUNT = 2'd2,
      SEL_MATCH = 2'd3
   } reg_sel_e;

   // control-word bit positions of source k
   function automatic int unsigned en_pos(input int unsigned k);
      return REG_W - 1 - 2 * k;
   endfunction

   function automatic int unsigned pend_pos(input int unsigned k);
      return REG_W - 2 - 2 * k;
   endfunction

endpackage

// File: rtl/fmirq_frame_cnt.sv
module fmirq_frame_cnt #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb_i,
   input  logic             clr_i,
   input  logic             match_we_i,
   input  logic [CNT_W-1:0] match_wd_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] match_o,
   output logic             hit_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] match_q;

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("fmirq_frame_cnt: CNT_W must lie in 1..32");
      end
   endgenerate

   // clear beats strobe; natural wrap on overflow
   always_comb begin
      if (clr_i)
         cnt_d = '0;
      else if (stb_i)
         cnt_d = cnt_q + 1'b1;
      else
         cnt_d = cnt_q;
   end

   // fire only on a change into the target value
   assign hit_o = (cnt_d != cnt_q) && (cnt_d == match_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         match_q <= '0;
      else if (match_we_i)
         match_q <= match_wd_i;
   end

   assign cnt_o   = cnt_q;
   assign match_o = match_q;

endmodule

// File: rtl/fmirq_src_cell.sv
module fmirq_src_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic wr_i,
   input  logic en_wd_i,
   input  logic clr_wd_i,
   output logic en_o,
   output logic pend_o
);

   logic en_q;
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (wr_i)
         en_q <= en_wd_i;
   end

   // event wins over a same-cycle write-one clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (evt_i)
         pend_q <= 1'b1;
      else if (wr_i && clr_wd_i)
         pend_q <= 1'b0;
   end

   assign en_o   = en_q;
   assign pend_o = pend_q;

endmodule

// File: rtl/fmirq_regif.sv
module fmirq_regif
   import fmirq_pkg::*;
#(
   parameter int unsigned          ADDR_W    = 8,
   parameter int unsigned          CNT_W     = 32,
   parameter logic [ADDR_W-1:0]    CTRL_OFF  = 'h00,
   parameter logic [ADDR_W-1:0]    COUNT_OFF = 'h40,
   parameter logic [ADDR_W-1:0]    MATCH_OFF = 'h50
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wen_i,
   input  logic [FIELD_W-1:0] ctrl_field_i,
   input  logic [CNT_W-1:0]   cnt_i,
   input  logic [CNT_W-1:0]   match_i,
   output logic               ctrl_we_o,
   output logic               count_we_o,
   output logic               match_we_o,
   output logic [REG_W-1:0]   rdata_o
);

   reg_sel_e sel;

   generate
      if (CTRL_OFF == COUNT_OFF || CTRL_OFF == MATCH_OFF || COUNT_OFF == MATCH_OFF) begin : g_bad_map
         $error("fmirq_regif: register offsets must differ");
      end
   endgenerate

   always_comb begin
      if (addr_i == CTRL_OFF)
         sel = SEL_CTRL;
      else if (addr_i == COUNT_OFF)
         sel = SEL_COUNT;
      else if (addr_i == MATCH_OFF)
         sel = SEL_MATCH;
      else
         sel = SEL_NONE;
   end

   assign ctrl_we_o  = wen_i && (sel == SEL_CTRL);
   assign count_we_o = wen_i && (sel == SEL_COUNT);
   assign match_we_o = wen_i && (sel == SEL_MATCH);

   logic [REG_W-1:0] cnt_ext;
   logic [REG_W-1:0] match_ext;

   generate
      if (CNT_W < REG_W) begin : g_pad
         assign cnt_ext   = {{(REG_W - CNT_W){1'b0}}, cnt_i};
         assign match_ext = {{(REG_W - CNT_W){1'b0}}, match_i};
      end else begin : g_full
         assign cnt_ext   = cnt_i;
         assign match_ext = match_i;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SEL_CTRL:  rdata_o = {ctrl_field_i, {ZERO_W{1'b0}}};
         SEL_COUNT: rdata_o = cnt_ext;
         SEL_MATCH: rdata_o = match_ext;
         default:   rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/fmirq_ctrl.sv
module fmirq_ctrl
   import fmirq_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       CNT_W     = 32,
   parameter logic [ADDR_W-1:0] CTRL_OFF  = 'h00,
   parameter logic [ADDR_W-1:0] COUNT_OFF = 'h40,
   parameter logic [ADDR_W-1:0] MATCH_OFF = 'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb_i,
   input  logic [6:0]        evt_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_wen_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   output logic              irq_o
);

   localparam int unsigned EXT_N = SRC_N - 1;

   generate
      if (REG_W != 32 || ZERO_W != 16) begin : g_bad_pack
         $error("fmirq_ctrl: source field must fill the upper half-word");
      end
      if (CNT_W > REG_W) begin : g_bad_cnt
         $error("fmirq_ctrl: counter wider than the register");
      end
   endgenerate

   logic               ctrl_we;
   logic               count_we;
   logic               match_we;
   logic               frame_hit;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   match_q;
   logic [SRC_N-1:0]   src_evt;
   logic [SRC_N-1:0]   en_q;
   logic [SRC_N-1:0]   pend_q;
   logic [FIELD_W-1:0] ctrl_field;

   fmirq_frame_cnt #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb_i      (frame_stb_i),
      .clr_i      (count_we),
      .match_we_i (match_we),
      .match_wd_i (reg_wdata_i[CNT_W-1:0]),
      .cnt_o      (cnt_q),
      .match_o    (match_q),
      .hit_o      (frame_hit)
   );

   assign src_evt = {evt_i[EXT_N-1:0], frame_hit};

   for (genvar k = 0; k < SRC_N; k++) begin : g_src
      localparam int unsigned EN_B = en_pos(k);
      localparam int unsigned PD_B = pend_pos(k);

      fmirq_src_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_i    (src_evt[k]),
         .wr_i     (ctrl_we),
         .en_wd_i  (reg_wdata_i[EN_B]),
         .clr_wd_i (reg_wdata_i[PD_B]),
         .en_o     (en_q[k]),
         .pend_o   (pend_q[k])
      );

      assign ctrl_field[EN_B - ZERO_W] = en_q[k];
      assign ctrl_field[PD_B - ZERO_W] = pend_q[k];
   end

   fmirq_regif #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .CTRL_OFF  (CTRL_OFF),
      .COUNT_OFF (COUNT_OFF),
      .MATCH_OFF (MATCH_OFF)
   ) u_regif (
      .addr_i       (reg_addr_i),
      .wen_i        (reg_wen_i),
      .ctrl_field_i (ctrl_field),
      .cnt_i        (cnt_q),
      .match_i      (match_q),
      .ctrl_we_o    (ctrl_we),
      .count_we_o   (count_we),
      .match_we_o   (match_we),
      .rdata_o      (reg_rdata_o)
   );

   assign irq_o = |(en_q & pend_q);

endmodule

// File: rtl/fmirq_chk.sv
module fmirq_chk #(
   parameter int unsigned       ADDR_W   = 8,
   parameter int unsigned       CNT_W    = 32,
   parameter logic [ADDR_W-1:0] CTRL_OFF = 'h00
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_stb_i,
   input logic [6:0]        evt_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [31:0]       reg_wdata_i,
   input logic [31:0]       reg_rdata_o,
   input logic              irq_o,
   input logic              ctrl_we,
   input logic              count_we,
   input logic              match_we,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  match_q,
   input logic [7:0]        en_q,
   input logic [7:0]        pend_q
);

   logic [6:0] clr_req;
   always_comb begin
      for (int j = 0; j < 7; j++)
         clr_req[j] = reg_wdata_i[28 - 2 * j];
   end

   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb_i && !count_we) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   a_r7_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
      count_we |=> (cnt_q == '0));

   a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q[7:1] & $past(evt_i)) == $past(evt_i)));

   a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> ((pend_q[7:1] & $past(clr_req & ~evt_i)) == 7'd0));

   a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == 8'd0) |-> !irq_o);

   a_r8_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_q[0]) && !$past(match_we)) |-> (cnt_q == match_q));

   a_r9_low_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == CTRL_OFF) |-> (reg_rdata_o[15:0] == 16'd0));

endmodule

bind fmirq_ctrl fmirq_chk #(
   .ADDR_W   (ADDR_W),
   .CNT_W    (CNT_W),
   .CTRL_OFF (CTRL_OFF)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_stb_i (frame_stb_i),
   .evt_i       (evt_i),
   .reg_addr_i  (reg_addr_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rdata_o (reg_rdata_o),
   .irq_o       (irq_o),
   .ctrl_we     (ctrl_we),
   .count_we    (count_we),
   .match_we    (match_we),
   .cnt_q       (cnt_q),
   .match_q     (match_q),
   .en_q        (en_q),
   .pend_q      (pend_q)
);

// File: tb/fmirq_ctrl_tb.sv
`timescale 1ns/1ps
module fmirq_ctrl_tb;

   localparam int unsigned CW   = 6;
   localparam int unsigned PER  = 1 << CW;
   localparam logic [7:0]  A_CTL = 8'h00;
   localparam logic [7:0]  A_CNT = 8'h40;
   localparam logic [7:0]  A_MAT = 8'h50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_stb_i = 1'b0;
   logic [6:0]  evt_i = '0;
   logic [7:0]  reg_addr_i = '0;
   logic        reg_wen_i = 1'b0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   fmirq_ctrl #(.ADDR_W(8), .CNT_W(CW)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_stb_i (frame_stb_i),
      .evt_i       (evt_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wen_i   (reg_wen_i),
      .reg_wdata_i (reg_wdata_i),
      .reg_rdata_o (reg_rdata_o),
      .irq_o       (irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr_i = a; reg_wdata_i = d; reg_wen_i = 1'b1;
      @(negedge clk);
      reg_wen_i = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr_i = a;
      #1;
      d = reg_rdata_o;
   endtask

   task automatic strobe();
      @(negedge clk);
      frame_stb_i = 1'b1;
      @(negedge clk);
      frame_stb_i = 1'b0;
   endtask

   task automatic pulse(input int j);
      @(negedge clk);
      evt_i = 7'd1 << j;
      @(negedge clk);
      evt_i = '0;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTL, v); check("R1 ctrl", v, 32'h0);
      rd(A_CNT, v); check("R1 count", v, 32'h0);
      rd(A_MAT, v); check("R1 match", v, 32'h0);
      check("R1 irq", {31'd0, irq_o}, 32'h0);

      // R2 R3 R5 sweep of the seven pulse sources
      for (int j = 0; j < 7; j++) begin
         logic [31:0] eb, pb;
         eb = 32'd1 << (29 - 2 * j);
         pb = 32'd1 << (28 - 2 * j);
         pulse(j);
         rd(A_CTL, v); check("R3 pend while disabled", v, pb);
         check("R3 no irq when disabled", {31'd0, irq_o}, 32'h0);
         wr(A_CTL, eb);
         rd(A_CTL, v); check("R2 enable above pending", v, eb | pb);
         check("R5 irq enabled+pending", {31'd0, irq_o}, 32'h1);
         wr(A_CTL, eb | pb);
         rd(A_CTL, v); check("R4 write-one clears", v, eb);
         check("R5 irq drops", {31'd0, irq_o}, 32'h0);
         wr(A_CTL, 32'h0);
      end

      // R4 event beats a same-cycle clear; zero write keeps flag
      pulse(0);
      @(negedge clk);
      reg_addr_i = A_CTL; reg_wdata_i = 32'h1000_0000; reg_wen_i = 1'b1; evt_i = 7'd1;
      @(negedge clk);
      reg_wen_i = 1'b0; evt_i = '0;
      rd(A_CTL, v); check("R4 event wins", v, 32'h1000_0000);
      wr(A_CTL, 32'h0);
      rd(A_CTL, v); check("R4 zero write keeps pending", v, 32'h1000_0000);
      wr(A_CTL, 32'h1000_0000);

      // R9 low half ignored
      wr(A_CTL, 32'h0000_FFFF);
      rd(A_CTL, v); check("R9 low half zero", v, 32'h0);

      // R10 unmapped offset
      wr(A_MAT, 32'd9);
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h44, 32'h0);
      rd(8'h20, v); check("R10 unmapped reads zero", v, 32'h0);
      rd(A_CTL, v); check("R10 ctrl untouched", v, 32'h0);
      rd(A_MAT, v); check("R10 match untouched", v, 32'd9);

      // R7 clear beats strobe
      strobe(); strobe(); strobe();
      rd(A_CNT, v); check("R6 three strobes", v, 32'd3);
      @(negedge clk);
      reg_addr_i = A_CNT; reg_wdata_i = 32'h2A; reg_wen_i = 1'b1; frame_stb_i = 1'b1;
      @(negedge clk);
      reg_wen_i = 1'b0; frame_stb_i = 1'b0;
      rd(A_CNT, v); check("R7 clear beats strobe", v, 32'd0);

      // R8 target written equal to count: no fire
      wr(A_MAT, 32'd0);
      rd(A_CTL, v); check("R8 no fire on equal target write", v, 32'h0);

      // R2 R5 frame source on bits 31/30, no repeat while held
      wr(A_MAT, 32'd2);
      wr(A_CTL, 32'h8000_0000);
      strobe(); strobe();
      rd(A_CTL, v); check("R2 frame source bits", v, 32'hC000_0000);
      check("R5 irq from frame match", {31'd0, irq_o}, 32'h1);
      wr(A_CTL, 32'hC000_0000);
      repeat (5) @(negedge clk);
      rd(A_CTL, v); check("R8 no repeat while equal", v, 32'h8000_0000);
      check("R8 irq stays low", {31'd0, irq_o}, 32'h0);
      wr(A_CTL, 32'h0);

      // R6 R8 sweep every target over one full period
      for (int m = 0; m < PER; m++) begin
         int hits, step, exp_step;
         logic bad_cnt;
         hits = 0; step = -1; bad_cnt = 1'b0;
         exp_step = (m == 0) ? PER : m;
         wr(A_MAT, m);
         wr(A_CNT, 32'h0);
         wr(A_CTL, 32'h4000_0000);
         for (int i = 1; i <= PER; i++) begin
            strobe();
            rd(A_CNT, v);
            if (v != (i % PER)) bad_cnt = 1'b1;
            rd(A_CTL, v);
            if (v[30]) begin
               hits++; step = i;
               wr(A_CTL, 32'h4000_0000);
            end
         end
         check("R6 count and wrap", {31'd0, bad_cnt}, 32'h0);
         check("R8 single fire", hits, 1);
         check("R8 fire strobe", step, exp_step);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule